// File: doc/BRIEF.md
# Busy-Gated Periodic Transfer Scheduler

This block sequences a serial master that shifts one byte at a time in full duplex. An internal interval counter raises a one-cycle tick every `TICK_CYCLES` system clocks. The default is 320000, which is 10 ms at a 32 MHz clock. On a tick the scheduler looks at two things. The first is the master's in-progress flag. The second is the slave's BUSY line, taken through a two-flop synchronizer. Only when both are low does it write the next transmit byte to the master with a one-cycle strobe. It then waits for the master's transfer-end pulse and latches the byte the master received. A tick whose conditions fail is dropped and is not retried. The scheduler simply waits for the next tick.

The transmit bytes alternate between 0x05 and 0x50, and reset always starts with 0x05. The alternation moves on only when a byte is actually written. With `edge_mode` high, the tick is ignored. A transfer then starts on a synchronized falling edge of BUSY. After each transfer the scheduler waits for a fresh falling edge, however long BUSY stays low.

The controller has three states. `ST_IDLE` waits for a trigger and goes to `ST_LOAD` when the trigger arrives with the gate open. `ST_LOAD` is the cycle in which the strobe and byte are presented, and it always goes to `ST_RUN` on the next clock. `ST_RUN` waits for the transfer-end pulse. On that pulse it captures the received byte and returns to `ST_IDLE`.

Top module: `xfer_sched`

## Requirements
- R1: While reset is asserted and right after it, `wr_stb` is 0, `wr_byte` is 0x00 and `rx_byte` is 0x00.
- R2: With `edge_mode` low and both `busy_in` and `mst_active` low, the first write after reset release appears as `wr_stb` high `TICK_CYCLES` clocks after release. Later writes follow at multiples of `TICK_CYCLES` clocks. No write starts while `mst_active` is high, in either mode.
- R3: With `edge_mode` low, a tick at which BUSY or `mst_active` is high writes nothing. `wr_stb` stays low until the next tick, even if the condition clears in between.
- R4: Written bytes alternate 0x05, 0x50, 0x05, and so on, with 0x05 first after reset. The byte is valid on `wr_byte` in the cycle `wr_stb` is high.
- R5: A tick or edge that is blocked does not advance the alternation.
- R6: `rx_byte` takes `mst_rx_byte` on the clock where `mst_done` is high during a transfer. A `mst_done` pulse while no transfer is pending leaves `rx_byte` unchanged.
- R7: With `edge_mode` high, ticks start nothing. A falling edge on `busy_in` produces `wr_stb` high on the third rising clock after the change, when `mst_active` is low.
- R8: With `edge_mode` high, after a transfer ends no new write starts while BUSY merely stays low. Only a new falling edge starts one.
- R9: Between a write and its `mst_done`, no further `wr_stb` is issued, whatever ticks or BUSY do.
- R10: `wr_stb` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_mode | input | 1 | 0: start on interval tick; 1: start on BUSY falling edge (hold static outside reset) |
| busy_in | input | 1 | Slave BUSY line, asynchronous |
| mst_active | input | 1 | Master reports a transfer in progress |
| mst_done | input | 1 | Master transfer-end pulse |
| mst_rx_byte | input | DATA_W | Byte received by the master, valid with `mst_done` |
| wr_stb | output | 1 | One-cycle write/start strobe to the master |
| wr_byte | output | DATA_W | Transmit byte presented with `wr_stb` |
| rx_byte | output | DATA_W | Last captured received byte |

## Verification
The bench first goes after dropped ticks. A design that retried a blocked tick would emit a strobe partway through the following interval instead of on the interval boundary. Blocked starts come next. A design that advanced the alternation on them would send 0x50 where 0x05 is due. In edge mode, a design that treated a low BUSY level as a trigger would fire repeatedly after a transfer, and a wrong synchronizer depth shows up as a strobe on the wrong clock after the falling edge. A transfer is also held open across several ticks to expose a sequencer that re-issues during `ST_RUN`, and a stray end pulse is sent while idle to expose a capture that does not depend on state.

// File: rtl/xfer_sched_pkg.sv
`timescale 1ns/1ps
package xfer_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } sched_state_t;
endpackage

// File: rtl/xfer_sched_tick.sv
`timescale 1ns/1ps
module xfer_sched_tick #(
    parameter int TICK_CYCLES = 320000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 2;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R3: ticks are isolated single-cycle events
    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/xfer_sched_busy.sv
`timescale 1ns/1ps
module xfer_sched_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    output logic busy_s,
    output logic busy_fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= busy_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign busy_s    = sync_q;
    assign busy_fall = prev_q & ~sync_q;

    // R7: one falling edge gives one trigger cycle
    a_r7_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        busy_fall |=> !busy_fall);
endmodule

// File: rtl/xfer_sched.sv
`timescale 1ns/1ps
module xfer_sched
    import xfer_sched_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          TICK_CYCLES = 320000,
    parameter logic [7:0]  PAT_FIRST   = 8'h05,
    parameter logic [7:0]  PAT_SECOND  = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_mode,
    input  logic              busy_in,
    input  logic              mst_active,
    input  logic              mst_done,
    input  logic [DATA_W-1:0] mst_rx_byte,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rx_byte
);
    localparam logic [DATA_W-1:0] BYTE_A = DATA_W'(PAT_FIRST);
    localparam logic [DATA_W-1:0] BYTE_B = DATA_W'(PAT_SECOND);

    logic tick, busy_s, busy_fall;
    logic trig, start_ok;
    sched_state_t state_q, state_d;
    logic              stb_q, sel_q;
    logic [DATA_W-1:0] byte_q, rx_q;

    xfer_sched_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    xfer_sched_busy u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_in  (busy_in),
        .busy_s   (busy_s),
        .busy_fall(busy_fall)
    );

    assign trig     = edge_mode ? busy_fall : tick;
    assign start_ok = trig && !mst_active && !busy_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  if (mst_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            sel_q  <= 1'b0;
            byte_q <= '0;
            rx_q   <= '0;
        end else begin
            stb_q <= (state_q == ST_IDLE) && start_ok;
            if ((state_q == ST_IDLE) && start_ok) begin
                byte_q <= sel_q ? BYTE_B : BYTE_A;
                sel_q  <= ~sel_q;
            end
            if ((state_q == ST_RUN) && mst_done)
                rx_q <= mst_rx_byte;
        end
    end

    assign wr_stb  = stb_q;
    assign wr_byte = byte_q;
    assign rx_byte = rx_q;

    // R10: strobe is a single-cycle pulse
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R2: a write only follows a cycle where master and slave were both free
    a_r2_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!mst_active && !busy_s));
    // R3: in tick mode a write only follows a tick
    a_r3_tick_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !$past(edge_mode)) |-> $past(tick));
    // R7: in edge mode a write only follows a BUSY falling edge
    a_r7_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && $past(edge_mode)) |-> $past(busy_fall));
    // R6: received byte only moves on an end pulse
    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mst_done) |-> $stable(rx_byte));
    // R4: only the two patterns are ever written
    a_r4_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_byte == BYTE_A || wr_byte == BYTE_B));
endmodule

// File: tb/xfer_sched_tb_top.sv
`timescale 1ns/1ps
module xfer_sched_tb_top;
    localparam int TICK = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic edge_mode = 1'b0;
    logic busy_in = 1'b0;
    logic mst_active = 1'b0;
    logic mst_done = 1'b0;
    logic [7:0] mst_rx = 8'h00;
    logic wr_stb;
    logic [7:0] wr_byte, rx_byte;

    int errs = 0;
    int checks = 0;
    int early = 0;
    logic [7:0] exp_rx = 8'h00;

    always #2.5 clk = ~clk;

    xfer_sched #(.DATA_W(8), .TICK_CYCLES(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .busy_in(busy_in),
        .mst_active(mst_active), .mst_done(mst_done), .mst_rx_byte(mst_rx),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .rx_byte(rx_byte)
    );

    // {busy[18], act[17], rx[16:9], expect_start[8], expect_byte[7:0]}
    localparam logic [18:0] VEC [7] = '{
        {1'b0, 1'b0, 8'hA1, 1'b1, 8'h50},
        {1'b1, 1'b0, 8'hB2, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h05},
        {1'b0, 1'b1, 8'hC3, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h50},
        {1'b1, 1'b1, 8'hD4, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h05}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wr_stb) early++;
        end
    endtask

    task automatic serve(input logic [7:0] rx);
        mst_active = 1'b1;
        step(3);
        mst_active = 1'b0;
        mst_rx = rx;
        mst_done = 1'b1;
        step(1);
        mst_done = 1'b0;
        exp_rx = rx;
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        edge_mode = mode;
        busy_in = 1'b0;
        mst_active = 1'b0;
        mst_done = 1'b0;
        exp_rx = 8'h00;
        repeat (3) @(negedge clk);
        chk(wr_stb == 1'b0, "R1", "strobe in reset", wr_stb, 0);
        chk(wr_byte == 8'h00, "R1", "wr_byte in reset", wr_byte, 0);
        chk(rx_byte == 8'h00, "R1", "rx_byte in reset", rx_byte, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        bit got;
        int k;
        // ---------------- tick mode ----------------
        do_reset(1'b0);
        k = 0;
        got = 1'b0;
        while (!got && k < 3 * TICK) begin
            @(negedge clk);
            k++;
            got = wr_stb;
        end
        chk(k == TICK, "R2", "first strobe delay", k, TICK);
        chk(wr_byte == 8'h05, "R4", "first byte", wr_byte, 8'h05);

        // table walk: one entry per tick interval
        for (int v = 0; v < 7; v++) begin
            int used;
            logic [18:0] e;
            e = VEC[v];
            busy_in = e[18];
            early = 0;
            used = 0;
            if (got) begin
                serve(e[16:9]);
                used = 4;
            end
            mst_active = e[17];
            step(TICK - 1 - used);
            @(negedge clk);
            got = wr_stb;
            chk(early == 0, "R3", $sformatf("strobe between ticks v%0d", v), early, 0);
            chk(got == e[8], "R5", $sformatf("start at tick v%0d", v), got, e[8]);
            if (e[8])
                chk(wr_byte == e[7:0], "R4", $sformatf("byte v%0d", v), wr_byte, e[7:0]);
            chk(rx_byte == exp_rx, "R6", $sformatf("rx v%0d", v), rx_byte, exp_rx);
        end

        // R9: transfer held open across ticks, master not flagging active
        mst_active = 1'b0;
        busy_in = 1'b0;
        early = 0;
        step(2 * TICK + 3);
        chk(early == 0, "R9", "strobe during open transfer", early, 0);
        mst_rx = 8'hE7;
        mst_done = 1'b1;
        @(negedge clk);
        mst_done = 1'b0;
        chk(rx_byte == 8'hE7, "R6", "capture on end", rx_byte, 8'hE7);
        // stray end pulse while idle (tick far away or blocked by busy)
        busy_in = 1'b1;
        step(3);
        mst_rx = 8'hEE;
        mst_done = 1'b1;
        @(negedge clk);
        mst_done = 1'b0;
        @(negedge clk);
        chk(rx_byte == 8'hE7, "R6", "stray end ignored", rx_byte, 8'hE7);

        // ---------------- edge mode ----------------
        do_reset(1'b1);
        early = 0;
        step(3 * TICK);
        chk(early == 0, "R7", "ticks ignored in edge mode", early, 0);
        busy_in = 1'b1;
        step(5);
        busy_in = 1'b0;
        early = 0;
        step(2);
        chk(early == 0, "R7", "strobe too early after fall", early, 0);
        @(negedge clk);
        chk(wr_stb == 1'b1, "R7", "strobe third clock after fall", wr_stb, 1);
        chk(wr_byte == 8'h05, "R4", "edge first byte", wr_byte, 8'h05);
        serve(8'h5A);
        chk(rx_byte == 8'h5A, "R6", "edge capture", rx_byte, 8'h5A);
        early = 0;
        step(3 * TICK);
        chk(early == 0, "R8", "no restart on held low", early, 0);
        // falling edge while master active is dropped
        busy_in = 1'b1;
        step(4);
        mst_active = 1'b1;
        busy_in = 1'b0;
        early = 0;
        step(6);
        chk(early == 0, "R2", "edge blocked by active", early, 0);
        mst_active = 1'b0;
        step(4);
        chk(early == 0, "R8", "no start after active clears", early, 0);
        busy_in = 1'b1;
        step(4);
        busy_in = 1'b0;
        early = 0;
        step(3);
        chk(early == 1 && wr_stb == 1'b1, "R7", "second edge start", early, 1);
        chk(wr_byte == 8'h50, "R5", "blocked edge kept order", wr_byte, 8'h50);
        step(1);
        chk(wr_stb == 1'b0, "R10", "strobe width", wr_stb, 0);
        serve(8'h3C);
        chk(rx_byte == 8'h3C, "R6", "second edge capture", rx_byte, 8'h3C);

        summary();
        $finish;
    end
endmodule